// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block is the program-counter unit of a small 8-bit processor core. It holds a 13-bit program counter, a 5-bit upper-address latch that software loads ahead of time, and an 8-entry return-address stack. The instruction decoder drives one-cycle strobes into it: advance, load the low byte, jump, call, return, and take the interrupt vector. The unit then presents the address of the next instruction to fetch.

The upper address bits are filled in two ways, depending on the operation. A low-byte load copies all five latch bits into the upper part of the counter. A jump or a call keeps its own 11-bit target and takes only the two highest latch bits as a page number. The return stack is a ring of registers. Pushing more than eight entries overwrites the oldest ones, and popping past empty just wraps the pointer. Nothing is reported for either case, and the pointer cannot be accessed from outside.

Top module: `prog_counter_unit`

## Requirements
- R1: After reset the counter, the upper-address latch and every stack entry are zero, so a low-byte load of D right after reset gives the counter value 0x00D (upper bits zero).
- R2: An advance strobe adds one to the counter, modulo 2^13, so 0x1FFF advances to 0x0000.
- R3: A low-byte load with data D makes the counter {latch[4:0], D}, with all 13 bits changing in the same cycle. A latch write in that same cycle affects only later loads.
- R4: A jump to 11-bit target T makes the counter {latch[4:3], T} and leaves the stack untouched.
- R5: A call to target T makes the counter {latch[4:3], T} and pushes the counter value plus one, modulo 2^13.
- R6: An interrupt-vector strobe sets the counter to 0x0004 and pushes the counter value it replaces.
- R7: A return loads the counter with the most recently pushed entry that has not been popped, and steps the stack pointer back by one.
- R8: The stack is circular with 8 entries. After nine pushes p1..p9, eight returns yield p9, p8, ..., p2, and a ninth return yields p9 again.
- R9: Pushes, pops and counter updates never alter the upper-address latch. Only a latch write changes it.
- R10: When several strobes arrive in the same cycle, only the highest-priority one acts. The order is vector, then return, then call, then jump, then low-byte load, then advance. The others have no effect on the counter or the stack.
- R11: With no strobe, or with only a latch write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance the counter by one |
| lowwr_i | input | 1 | Load the counter low byte (upper bits taken from the latch) |
| low_data_i | input | 8 | Low-byte data |
| hiwr_i | input | 1 | Write the upper-address latch |
| hi_data_i | input | 5 | Upper-address latch data |
| jump_i | input | 1 | Jump to the paged target |
| call_i | input | 1 | Call the paged target, pushing the return address |
| target_i | input | 11 | Jump or call target within a page |
| ret_i | input | 1 | Return: pop the stack into the counter |
| vec_i | input | 1 | Take the interrupt vector, pushing the current counter |
| pc_o | output | 13 | Current program counter |

## Verification
Every result of this block is due exactly one rising edge after its strobe: the counter, the stack top and the latch are each a single register stage. The bench therefore applies each strobe on a falling edge, lets one rising edge pass, and reads `pc_o` on the following falling edge. The stack and the latch have no port of their own, so their contents are observed through later returns and later low-byte loads. Each of those steps is also checked one edge after its own strobe.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
    localparam int PC_W      = 13;
    localparam int LOW_W     = 8;
    localparam int HI_W      = PC_W - LOW_W;
    localparam int TGT_W     = 11;
    localparam int PAGE_W    = PC_W - TGT_W;
    localparam int STK_DEPTH = 8;
    localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(4);

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_LOWWR = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5,
        OP_VEC   = 3'd6
    } pc_op_e;
endpackage

// File: rtl/pcu_op_select.sv
`timescale 1ns/1ps
module pcu_op_select
    import pcu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_i,
    input  logic   lowwr_i,
    input  logic   jump_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   vec_i,
    output pc_op_e op_o
);
    // Fixed priority: vector, return, call, jump, low write, step
    always_comb begin
        if (vec_i)        op_o = OP_VEC;
        else if (ret_i)   op_o = OP_RET;
        else if (call_i)  op_o = OP_CALL;
        else if (jump_i)  op_o = OP_JUMP;
        else if (lowwr_i) op_o = OP_LOWWR;
        else if (step_i)  op_o = OP_STEP;
        else              op_o = OP_HOLD;
    end

    AST_VEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_i |-> op_o == OP_VEC); // R10
    AST_RET_OVER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !vec_i) |-> op_o == OP_RET); // R10
endmodule

// File: rtl/pcu_upper_latch.sv
`timescale 1ns/1ps
module pcu_upper_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.val = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.val;

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> q_o == $past(data_i)); // R9
endmodule

// File: rtl/pcu_stack.sv
`timescale 1ns/1ps
module pcu_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [PTR_W-1:0]        ptr;
    } stk_state_t;

    stk_state_t       st_d, st_q;
    logic [PTR_W-1:0] top_idx;

    // Pointer names the next free slot; the top is one below it (ring wrap)
    assign top_idx = st_q.ptr - PTR_W'(1);
    assign top_o   = st_q.ent[top_idx];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.ent[st_q.ptr] = push_data_i;
            st_d.ptr           = st_q.ptr + PTR_W'(1);
        end else if (pop_i) begin
            st_d.ptr = top_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i)); // R5
    AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> st_q.ptr == PTR_W'($past(st_q.ptr) + PTR_W'(1))); // R8
    AST_POP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> st_q.ptr == PTR_W'($past(st_q.ptr) - PTR_W'(1))); // R7
    AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !push_i) |=> $stable(st_q.ptr)); // R4
endmodule

// File: rtl/pcu_seq.sv
`timescale 1ns/1ps
module pcu_seq
    import pcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pc_op_e           op_i,
    input  logic [LOW_W-1:0] low_data_i,
    input  logic [TGT_W-1:0] target_i,
    input  logic [HI_W-1:0]  latch_i,
    input  logic [PC_W-1:0]  stack_top_i,
    output logic             push_o,
    output logic             pop_o,
    output logic [PC_W-1:0]  push_data_o,
    output logic [PC_W-1:0]  pc_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_state_t;

    seq_state_t      st_d, st_q;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] paged_tgt;

    assign pc_inc    = st_q.pc + PC_W'(1);
    assign paged_tgt = {latch_i[HI_W-1 -: PAGE_W], target_i};

    always_comb begin
        st_d        = st_q;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_inc;
        unique case (op_i)
            OP_STEP:  st_d.pc = pc_inc;
            OP_LOWWR: st_d.pc = {latch_i, low_data_i};
            OP_JUMP:  st_d.pc = paged_tgt;
            OP_CALL: begin
                st_d.pc = paged_tgt;
                push_o  = 1'b1;
            end
            OP_RET: begin
                st_d.pc = stack_top_i;
                pop_o   = 1'b1;
            end
            OP_VEC: begin
                st_d.pc     = VEC_ADDR;
                push_o      = 1'b1;
                push_data_o = st_q.pc;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_STEP |=> pc_o == PC_W'($past(pc_o) + PC_W'(1))); // R2
    AST_LOWWR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_LOWWR |=> pc_o == {$past(latch_i), $past(low_data_i)}); // R3
    AST_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_JUMP || op_i == OP_CALL) |=> pc_o[TGT_W-1:0] == $past(target_i)); // R4
    AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_VEC |=> pc_o == VEC_ADDR); // R6
    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_HOLD |=> $stable(pc_o)); // R11
endmodule

// File: rtl/prog_counter_unit.sv
`timescale 1ns/1ps
module prog_counter_unit
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              lowwr_i,
    input  logic [LOW_W-1:0]  low_data_i,
    input  logic              hiwr_i,
    input  logic [HI_W-1:0]   hi_data_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              ret_i,
    input  logic              vec_i,
    output logic [PC_W-1:0]   pc_o
);
    pc_op_e          op;
    logic [HI_W-1:0] latch_q;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] push_data;
    logic            push, pop;

    pcu_op_select u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .lowwr_i (lowwr_i),
        .jump_i  (jump_i),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .vec_i   (vec_i),
        .op_o    (op)
    );

    pcu_upper_latch #(.W(HI_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (hiwr_i),
        .data_i (hi_data_i),
        .q_o    (latch_q)
    );

    pcu_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (stk_top)
    );

    pcu_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .low_data_i  (low_data_i),
        .target_i    (target_i),
        .latch_i     (latch_q),
        .stack_top_i (stk_top),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data),
        .pc_o        (pc_o)
    );

    AST_RET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RET |=> pc_o == $past(stk_top)); // R7
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CALL |=> stk_top == PC_W'($past(pc_o) + PC_W'(1))); // R5
    AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !hiwr_i |=> $stable(latch_q)); // R9
    AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R10
endmodule

// File: tb/prog_counter_unit_tb_top.sv
`timescale 1ns/1ps
module prog_counter_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, lowwr_i = 1'b0, hiwr_i = 1'b0;
    logic        jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, vec_i = 1'b0;
    logic [7:0]  low_data_i = '0;
    logic [4:0]  hi_data_i = '0;
    logic [10:0] target_i = '0;
    logic [12:0] pc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    prog_counter_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .lowwr_i(lowwr_i),
        .low_data_i(low_data_i), .hiwr_i(hiwr_i), .hi_data_i(hi_data_i),
        .jump_i(jump_i), .call_i(call_i), .target_i(target_i),
        .ret_i(ret_i), .vec_i(vec_i), .pc_o(pc_o)
    );

    task automatic chk(input string req, input logic [12:0] exp);
        n_checks++;
        if (pc_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pc actual 0x%04h expected 0x%04h", req, pc_o, exp);
        end
    endtask

    // One rising edge, then back to the falling edge with strobes cleared
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        step_i = 0; lowwr_i = 0; hiwr_i = 0; jump_i = 0;
        call_i = 0; ret_i = 0; vec_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_latch(input logic [4:0] v);
        hiwr_i = 1; hi_data_i = v; tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset pc", 13'h0000);
        lowwr_i = 1; low_data_i = 8'h5A; tick();
        chk("R1 latch zero after reset", 13'h005A);
        ret_i = 1; tick();
        chk("R1 empty stack entry zero", 13'h0000);
    endtask

    task automatic t_step();
        lowwr_i = 1; low_data_i = 8'h5A; tick();
        step_i = 1; tick();
        chk("R2 step", 13'h005B);
        set_latch(5'h1F);
        lowwr_i = 1; low_data_i = 8'hFF; tick();
        chk("R3 full low load", 13'h1FFF);
        step_i = 1; tick();
        chk("R2 wrap", 13'h0000);
    endtask

    task automatic t_lowwr();
        set_latch(5'h03);
        hiwr_i = 1; hi_data_i = 5'h0A; lowwr_i = 1; low_data_i = 8'h10; tick();
        chk("R3 old latch used", 13'h0310);
        lowwr_i = 1; low_data_i = 8'h20; tick();
        chk("R3 new latch used", 13'h0A20);
    endtask

    task automatic t_jump_call();
        // latch 0x0A: bits 4:3 = 01
        jump_i = 1; target_i = 11'h123; tick();
        chk("R4 jump page", 13'h0923);
        call_i = 1; target_i = 11'h456; tick();
        chk("R5 call page", 13'h0C56);
        jump_i = 1; target_i = 11'h010; tick();
        chk("R4 jump inside call", 13'h0810);
        ret_i = 1; tick();
        chk("R5 R7 return pc+1, jump no push", 13'h0924);
        lowwr_i = 1; low_data_i = 8'h00; tick();
        chk("R9 latch kept over push/pop", 13'h0A00);
    endtask

    task automatic t_vec();
        step_i = 1; tick();
        vec_i = 1; tick();
        chk("R6 vector", 13'h0004);
        ret_i = 1; tick();
        chk("R6 vector pushed current pc", 13'h0A01);
    endtask

    task automatic t_circular();
        logic [12:0] pushed [1:9];
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            pushed[k] = (k == 1) ? 13'h001 : 13'((k - 1) * 16 + 1);
            call_i = 1; target_i = 11'(k * 16); tick();
        end
        chk("R8 after nine calls", 13'h0090);
        for (int k = 9; k >= 2; k--) begin
            ret_i = 1; tick();
            chk($sformatf("R8 pop %0d", 10 - k), pushed[k]);
        end
        ret_i = 1; tick();
        chk("R8 pop past empty wraps", pushed[9]);
    endtask

    task automatic t_priority();
        do_reset();
        lowwr_i = 1; low_data_i = 8'h40; tick();
        vec_i = 1; ret_i = 1; call_i = 1; step_i = 1; lowwr_i = 1; tick();
        chk("R10 vector wins", 13'h0004);
        ret_i = 1; call_i = 1; step_i = 1; tick();
        chk("R10 return wins", 13'h0040);
        call_i = 1; jump_i = 1; lowwr_i = 1; low_data_i = 8'h77; step_i = 1;
        target_i = 11'h200; tick();
        chk("R10 call wins", 13'h0200);
        jump_i = 1; target_i = 11'h300; lowwr_i = 1; low_data_i = 8'h11; step_i = 1; tick();
        chk("R10 jump wins", 13'h0300);
        lowwr_i = 1; low_data_i = 8'h22; step_i = 1; tick();
        chk("R10 low load wins", 13'h0022);
        ret_i = 1; tick();
        chk("R10 only call pushed", 13'h0041);
    endtask

    task automatic t_hold();
        repeat (3) tick();
        chk("R11 idle hold", 13'h0041);
        set_latch(5'h15);
        chk("R11 latch write alone holds pc", 13'h0041);
        lowwr_i = 1; low_data_i = 8'h01; tick();
        chk("R9 latch write visible", 13'h1501);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_step();
        t_lowwr();
        t_jump_call();
        t_vec();
        t_circular();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule